// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block sends bytes as asynchronous serial frames. A producer pushes bytes into a 16-entry transmit queue. A serializer takes them out one at a time and shifts each out as a frame. The frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts 16 pulses of an externally supplied baud tick.

Hardware flow control can be switched on with `flow_en`. The active-low clear-to-send input `cts_n` passes through a two-flop synchronizer. The synchronized level is consulted only at the point where a new frame would begin: the serializer is idle and the queue holds data. A frame already on the line always runs to its stop bit. While clear-to-send is withheld, the line rests at mark (logic 1) and the pending byte stays queued. When clear-to-send returns, the next queued byte goes out. With `flow_en` low, `cts_n` has no influence. The block has no interrupt output, so a change on `cts_n` never disturbs the host.

The write side is valid/ready. A byte is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly while the queue is full. A producer that keeps `wr_valid` high waits without loss. A byte offered while `wr_ready` is low is not stored. The serial side has no back-pressure other than `cts_n`.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, `txd` is 1, `fifo_empty` is 1, `fifo_full` is 0 and `wr_ready` is 1.
- R2: Every frame is one start bit of 0, then eight data bits with bit 0 first, then one stop bit of 1. Each bit holds for 16 `baud_tick` pulses.
- R3: Bytes leave in the order they were accepted. After 16 accepted bytes that have not been sent, `fifo_full` is 1 and `wr_ready` is 0. A byte offered while `wr_ready` is 0 is not stored and never transmitted. `fifo_empty` returns to 1 once every byte has been sent.
- R4: With `flow_en`=1 and the synchronized `cts_n` high when the serializer is idle, no frame starts. `txd` stays 1 and the queued byte remains (`fifo_empty` stays 0).
- R5: If `cts_n` rises during a frame while `flow_en`=1, that frame still completes intact. Only the following frame is held back.
- R6: With `flow_en`=1, an idle serializer and a non-empty queue, `cts_n` falling (changed between clock edges) makes `txd` drop to the start bit after the third following rising clock edge, and not earlier.
- R7: With `flow_en`=0, queued bytes are sent whatever the level of `cts_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer offers a byte |
| wr_data | input | 8 | Byte offered |
| wr_ready | output | 1 | Queue can accept a byte (not full) |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| flow_en | input | 1 | 1 lets `cts_n` gate frame starts |
| txd | output | 1 | Serial output, idles at 1 |

## Verification
The bench withdraws clear-to-send in the middle of a frame. A design that gates on the raw level would corrupt or shorten that frame, and the bit-by-bit scoreboard would flag it. It holds clear-to-send off with data queued and watches the line. A design that leaks a start bit, or drops the byte from the queue, shows up as an unexpected frame, a low `txd` or a `fifo_empty` flag that reads 1. It also fills the queue, offers one more byte, and times the restart to the exact clock edge. This catches an off-by-one full flag, a stored overflow byte, and a synchronizer with the wrong number of stages.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/tx_byte_queue.sv
module tx_byte_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      count;
  logic             push;

  assign full     = (count == (AW+1)'(DEPTH));
  assign empty    = (count == '0);
  assign in_ready = !full;
  assign push     = in_valid && in_ready;
  assign head     = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (full && count == $past(count)));  // R3
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);  // R3
endmodule

// File: rtl/cts_synchronizer.sv
module cts_synchronizer #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import uart_tx_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             flow_en,
  input  logic             cts_n_sync,
  input  logic             q_empty,
  input  logic [WIDTH-1:0] q_head,
  output logic             pop,
  output logic             txd
);
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam int BW = $clog2(WIDTH);

  tx_state_e        state;
  logic [WIDTH-1:0] shreg;
  logic [BW-1:0]    bit_idx;
  logic [TW-1:0]    tick_cnt;
  logic             bit_done;
  logic             launch;

  assign launch   = (state == ST_IDLE) && !q_empty && (!flow_en || !cts_n_sync);
  assign pop      = launch;
  assign bit_done = baud_tick && (tick_cnt == TW'(TICKS_PER_BIT-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bit_idx  <= '0;
      tick_cnt <= '0;
    end else begin
      if (state != ST_IDLE && baud_tick)
        tick_cnt <= bit_done ? '0 : tick_cnt + 1'b1;
      unique case (state)
        ST_IDLE: if (launch) begin
          shreg    <= q_head;
          tick_cnt <= '0;
          state    <= ST_START;
        end
        ST_START: if (bit_done) begin
          bit_idx <= '0;
          state   <= ST_DATA;
        end
        ST_DATA: if (bit_done) begin
          shreg   <= shreg >> 1;
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == BW'(WIDTH-1)) state <= ST_STOP;
        end
        ST_STOP: if (bit_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      default:  txd = 1'b1;
    endcase
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && flow_en && cts_n_sync) |=> (state == ST_IDLE && txd));  // R4
  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START || state == ST_DATA) |=> (state != ST_IDLE));  // R5
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !baud_tick) |=> $stable(txd));  // R2
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !flow_en && !q_empty) |=> (state == ST_START));  // R7
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
  parameter int WIDTH         = 8,
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  output logic             fifo_full,
  output logic             fifo_empty,
  input  logic             baud_tick,
  input  logic             cts_n,
  input  logic             flow_en,
  output logic             txd
);
  logic             pop;
  logic [WIDTH-1:0] head;
  logic             cts_n_sync;

  tx_byte_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_valid), .in_data(wr_data), .in_ready(wr_ready),
    .pop(pop), .head(head), .full(fifo_full), .empty(fifo_empty)
  );

  cts_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cts_n), .sync_out(cts_n_sync)
  );

  tx_frame_shifter #(.WIDTH(WIDTH), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .flow_en(flow_en), .cts_n_sync(cts_n_sync),
    .q_empty(fifo_empty), .q_head(head), .pop(pop), .txd(txd)
  );

  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop) |=> !wr_ready);  // R3
endmodule

// File: tb/tb_uart_tx_flow.sv
module tb_uart_tx_flow;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, fifo_full, fifo_empty, txd;
  logic       baud_tick = 1'b0;
  logic       cts_n = 1'b0;
  logic       flow_en = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  uart_tx_flow dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .baud_tick(baud_tick), .cts_n(cts_n), .flow_en(flow_en), .txd(txd)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Monitor: decodes frames tick by tick and scores them against exp_q.
  initial begin
    bit in_frame = 0;
    bit prev = 1;
    int tcnt = 0;
    logic [9:0] bits = '0;
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
        in_frame = 0;
        prev = 1;
      end else if (!in_frame) begin
        if (prev && !txd) begin
          in_frame = 1;
          tcnt = 0;
        end
      end else begin
        if (baud_tick) begin
          tcnt++;
          if (tcnt % 16 == 8) begin
            bits[tcnt / 16] = txd;
            if (tcnt == 152) begin
              in_frame = 0;
              check(bits[0] == 1'b0 && bits[9] == 1'b1, "R2 start/stop",
                    {bits[9], bits[0]}, 2'b10);
              if (exp_q.size() == 0) begin
                check(0, "R4 unexpected frame", bits[8:1], 0);
              end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(bits[8:1] == e, "R2/R3 data order", bits[8:1], e);
              end
            end
          end
        end
      end
      prev = txd;
    end
  end

  task automatic wait_drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || !fifo_empty) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
    check(fifo_full == 1'b0 && wr_ready == 1'b1, "R1 full/ready", {fifo_full, wr_ready}, 2'b01);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 basic frames, flow control off
    push(8'hA5);
    push(8'h01);
    push(8'h80);
    wait_drain("R2 basic drain");

    // R7 flow control disabled ignores cts_n
    cts_n = 1'b1;
    flow_en = 1'b0;
    push(8'h3C);
    push(8'hFF);
    wait_drain("R7 sent with cts_n high");

    // R4 stall: flow on, cts withheld
    flow_en = 1'b1;
    repeat (5) @(negedge clk);
    push(8'h5A);
    begin
      bit low_seen = 0;
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        if (!txd) low_seen = 1;
      end
      check(!low_seen, "R4 line held at mark", low_seen, 0);
      check(fifo_empty == 1'b0, "R4 byte kept queued", fifo_empty, 0);
    end

    // R6 restart latency
    @(negedge clk);
    cts_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(txd == 1'b1, "R6 no early start", txd, 1);
    @(negedge clk);
    check(txd == 1'b0, "R6 start on third edge", txd, 0);
    wait_drain("R6 resumed frame");

    // R5 cts withdrawn mid-frame
    push(8'hC3);
    push(8'h96);
    while (txd) @(negedge clk);
    repeat (100) @(negedge clk);
    cts_n = 1'b1;
    repeat (1500) @(negedge clk);
    check(exp_q.size() == 1, "R5 first frame finished, second held", exp_q.size(), 1);
    check(txd == 1'b1 && fifo_empty == 1'b0, "R5 line idle, byte queued",
          {txd, fifo_empty}, 2'b10);
    cts_n = 1'b0;
    wait_drain("R5 second frame after release");

    // R3 fill, overflow offer, drain
    cts_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 16; i++) push(8'(8'h10 + i));
    @(negedge clk);
    check(fifo_full == 1'b1 && wr_ready == 1'b0, "R3 full after 16",
          {fifo_full, wr_ready}, 2'b10);
    wr_valid = 1'b1;
    wr_data  = 8'hEE;
    check(wr_ready == 1'b0, "R3 overflow offer refused", wr_ready, 0);
    @(negedge clk);
    wr_valid = 1'b0;
    cts_n = 1'b0;
    wait_drain("R3 sixteen in order, overflow byte absent");
    check(fifo_empty == 1'b1 && fifo_full == 1'b0, "R3 empty after drain",
          {fifo_empty, fifo_full}, 2'b10);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule